// File: doc/BRIEF.md
# Indirect Command and Status Register Bridge

The bridge lets a host on a 64-bit register bus reach a narrower downstream byte-addressed bus through four word registers. The host stages write data in a data register, then writes a single control word carrying the direction, the byte count and the 32-bit downstream address. That one write launches the complete downstream transaction: the bridge raises a valid/ready request, waits for the response, and records the outcome in a status register.

Software learns the result by polling the status register. The register shows zero while a transaction is outstanding. Once the response has arrived it shows a done flag, together with the four returned bytes for a read. Reading the register hands its contents back and clears it in the same access, so each result is seen exactly once. A read that the downstream side rejects yields all ones in the data field. A write command reports done whatever the downstream side answered.

Top module: `indirect_cmd_bridge`

## Requirements
- R1: Host address bits [4:3] pick the register: 0 control, 1 reset, 2 status, 3 data. Only accesses with `hsize_i` equal to 8 take effect. Any other size is still acknowledged, returns zero and changes nothing.
- R2: Every host access is acknowledged by `hack_o` exactly one cycle after it is presented, and `hrdata_o` carries the read value in that cycle.
- R3: A control write launches one downstream request. Bit 48 set means read and clear means write (`dwe_o` high). Bits 59:56 give `dsize_o` and bits 31:0 give `daddr_o`. `dreq_o` and its fields hold steady until `dready_i` is seen.
- R4: A control write whose size field exceeds 8 is dropped: no request is made and the status register keeps its value. A size of exactly 8 is accepted.
- R5: A read response without error sets status to bit 11 (done) plus the four returned bytes in bits 57:26. Byte lane 0 (`drdata_i[7:0]`, the first byte) lands in the most significant position, bits 57:50.
- R6: A read response with `derr_i` set gives status bit 11 with bits 57:26 all ones.
- R7: For a write, `dwdata_o` carries the data register with its most significant byte in lane 0 (`dwdata_o[7:0]`). On the response, status becomes bit 11 alone, regardless of `derr_i`.
- R8: A status read returns the value and clears the register to zero. A status write has no effect.
- R9: A data write stores `hwdata_i[63:32]`. A data read returns the stored word in bits 63:32, with bits 31:0 zero.
- R10: Control and reset reads return zero. A reset write changes nothing.
- R11: While a transaction is outstanding, further control writes are ignored and status reads return zero. Launching a transaction clears the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hreq_i | input | 1 | Host access strobe, one cycle per access |
| hwe_i | input | 1 | Host access is a write |
| haddr_i | input | HADDR_W | Host byte address; bits [4:3] select the register |
| hsize_i | input | 4 | Access size in bytes; only 8 is honoured |
| hwdata_i | input | 64 | Host write data |
| hack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| hrdata_o | output | 64 | Read data, valid with hack_o |
| dreq_o | output | 1 | Downstream request valid |
| dready_i | input | 1 | Downstream request accepted |
| daddr_o | output | DADDR_W | Downstream byte address |
| dwe_o | output | 1 | Downstream request is a write |
| dsize_o | output | 4 | Downstream transfer size in bytes |
| dwdata_o | output | DW | Downstream write data, lane 0 sent first |
| drsp_i | input | 1 | Downstream response valid |
| drdata_i | input | DW | Downstream read data, lane 0 received first |
| derr_i | input | 1 | Downstream response signals failure |

## Verification
The bound checker watches, on every cycle, the acknowledge timing and the request hold under back-pressure. It also checks that a launch follows a legal control write, that an oversized or mid-flight control write raises no request, and that control, reset, status-in-flight and narrow reads return zero. The exact status words for read success, read failure and write completion, the byte lane order in both directions, and clear-on-read depend on data that crosses several cycles and the downstream handshake. Those are shown only by the bench's scenarios against its behavioural model. The same applies to a dropped command leaving an older status intact and to a busy-time command leaving the captured address unchanged.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int HOST_DW       = 64;
  localparam int SZ_W          = 4;
  localparam int CTL_RD_BIT    = 48;
  localparam int CTL_SZ_LSB    = 56;
  localparam int STAT_DONE_BIT = 11;
  localparam int STAT_RD_LSB   = 26;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/bridge_byte_rev.sv
module bridge_byte_rev #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign out_o[8*b +: 8] = in_i[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/bridge_host_if.sv
module bridge_host_if
  import bridge_pkg::*;
#(
  parameter int HADDR_W = 8,
  parameter int DW      = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hreq_i,
  input  logic               hwe_i,
  input  logic [HADDR_W-1:0] haddr_i,
  input  logic [SZ_W-1:0]    hsize_i,
  input  logic [HOST_DW-1:0] hwdata_i,
  output logic               hack_o,
  output logic [HOST_DW-1:0] hrdata_o,
  output logic               ctl_wr_o,
  output logic               stat_rd_o,
  output logic [HOST_DW-1:0] ctl_word_o,
  output logic [DW-1:0]      data_q_o,
  input  logic [HOST_DW-1:0] stat_view_i
);
  localparam int FULL_BYTES = HOST_DW / 8;

  reg_sel_e           sel;
  logic               full, wr, rd;
  logic [HOST_DW-1:0] rd_mux;
  logic               hack_q;
  logic [HOST_DW-1:0] hrdata_q;
  logic [DW-1:0]      data_q;

  assign sel  = reg_sel_e'(haddr_i[4:3]);
  assign full = (hsize_i == SZ_W'(FULL_BYTES));
  assign wr   = hreq_i & hwe_i & full;
  assign rd   = hreq_i & ~hwe_i & full;

  assign ctl_wr_o   = wr & (sel == SEL_CTL);
  assign stat_rd_o  = rd & (sel == SEL_STAT);
  assign ctl_word_o = hwdata_i;
  assign data_q_o   = data_q;

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = stat_view_i;
      SEL_DATA: rd_mux = {data_q, {(HOST_DW-DW){1'b0}}};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hack_q   <= 1'b0;
      hrdata_q <= '0;
      data_q   <= '0;
    end else begin
      hack_q   <= hreq_i;
      hrdata_q <= rd ? rd_mux : '0;
      if (wr && sel == SEL_DATA) data_q <= hwdata_i[HOST_DW-1 -: DW];
    end
  end

  assign hack_o   = hack_q;
  assign hrdata_o = hrdata_q;
endmodule

// File: rtl/bridge_stat_reg.sv
module bridge_stat_reg
  import bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic               done_i,
  input  logic [HOST_DW-1:0] done_word_i,
  input  logic               rd_clr_i,
  input  logic               busy_i,
  output logic [HOST_DW-1:0] stat_view_o
);
  logic [HOST_DW-1:0] stat_q;

  // completion outranks everything; launch and completion never coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_q <= '0;
    else if (done_i)    stat_q <= done_word_i;
    else if (launch_i)  stat_q <= '0;
    else if (rd_clr_i)  stat_q <= '0;
  end

  assign stat_view_o = busy_i ? '0 : stat_q;
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
#(
  parameter int DADDR_W   = 32,
  parameter int DW        = 32,
  parameter int MAX_BYTES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_wr_i,
  input  logic [HOST_DW-1:0] ctl_word_i,
  input  logic [DW-1:0]      data_q_i,
  output logic               busy_o,
  output logic               launch_o,
  output logic               done_o,
  output logic [HOST_DW-1:0] done_word_o,
  output logic               dreq_o,
  input  logic               dready_i,
  output logic [DADDR_W-1:0] daddr_o,
  output logic               dwe_o,
  output logic [SZ_W-1:0]    dsize_o,
  output logic [DW-1:0]      dwdata_o,
  input  logic               drsp_i,
  input  logic [DW-1:0]      drdata_i,
  input  logic               derr_i
);
  seq_st_e            st_q;
  logic [SZ_W-1:0]    size_f;
  logic               size_ok;
  logic [DW-1:0]      wdata_sw, rdata_sw;
  logic [DADDR_W-1:0] addr_q;
  logic               we_q;
  logic [SZ_W-1:0]    size_q;
  logic [DW-1:0]      wdata_q;

  assign size_f   = ctl_word_i[CTL_SZ_LSB +: SZ_W];
  assign size_ok  = (size_f <= SZ_W'(MAX_BYTES));
  assign launch_o = ctl_wr_i & (st_q == ST_IDLE) & size_ok;
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_WAIT) & drsp_i;

  bridge_byte_rev #(.W(DW)) u_wr_rev (.in_i(data_q_i), .out_o(wdata_sw));
  bridge_byte_rev #(.W(DW)) u_rd_rev (.in_i(drdata_i), .out_o(rdata_sw));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      size_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch_o) begin
          st_q    <= ST_REQ;
          addr_q  <= ctl_word_i[DADDR_W-1:0];
          we_q    <= ~ctl_word_i[CTL_RD_BIT];
          size_q  <= size_f;
          wdata_q <= wdata_sw;
        end
        ST_REQ:  if (dready_i) st_q <= ST_WAIT;
        ST_WAIT: if (drsp_i)   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    done_word_o = '0;
    done_word_o[STAT_DONE_BIT] = 1'b1;
    if (!we_q) done_word_o[STAT_RD_LSB +: DW] = derr_i ? '1 : rdata_sw;
  end

  assign dreq_o   = (st_q == ST_REQ);
  assign daddr_o  = addr_q;
  assign dwe_o    = we_q;
  assign dsize_o  = size_q;
  assign dwdata_o = wdata_q;
endmodule

// File: rtl/indirect_cmd_bridge.sv
module indirect_cmd_bridge
  import bridge_pkg::*;
#(
  parameter int HADDR_W   = 8,
  parameter int DADDR_W   = 32,
  parameter int DW        = 32,
  parameter int MAX_BYTES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hreq_i,
  input  logic               hwe_i,
  input  logic [HADDR_W-1:0] haddr_i,
  input  logic [3:0]         hsize_i,
  input  logic [63:0]        hwdata_i,
  output logic               hack_o,
  output logic [63:0]        hrdata_o,
  output logic               dreq_o,
  input  logic               dready_i,
  output logic [DADDR_W-1:0] daddr_o,
  output logic               dwe_o,
  output logic [3:0]         dsize_o,
  output logic [DW-1:0]      dwdata_o,
  input  logic               drsp_i,
  input  logic [DW-1:0]      drdata_i,
  input  logic               derr_i
);
  logic               ctl_wr, stat_rd, busy, launch, done;
  logic [HOST_DW-1:0] ctl_word, done_word, stat_view;
  logic [DW-1:0]      data_q;

  bridge_host_if #(.HADDR_W(HADDR_W), .DW(DW)) u_host (
    .clk_i, .rst_ni, .hreq_i, .hwe_i, .haddr_i, .hsize_i, .hwdata_i,
    .hack_o, .hrdata_o,
    .ctl_wr_o(ctl_wr), .stat_rd_o(stat_rd), .ctl_word_o(ctl_word),
    .data_q_o(data_q), .stat_view_i(stat_view)
  );

  bridge_seq #(.DADDR_W(DADDR_W), .DW(DW), .MAX_BYTES(MAX_BYTES)) u_seq (
    .clk_i, .rst_ni,
    .ctl_wr_i(ctl_wr), .ctl_word_i(ctl_word), .data_q_i(data_q),
    .busy_o(busy), .launch_o(launch), .done_o(done), .done_word_o(done_word),
    .dreq_o, .dready_i, .daddr_o, .dwe_o, .dsize_o, .dwdata_o,
    .drsp_i, .drdata_i, .derr_i
  );

  bridge_stat_reg u_stat (
    .clk_i, .rst_ni,
    .launch_i(launch), .done_i(done), .done_word_i(done_word),
    .rd_clr_i(stat_rd), .busy_i(busy), .stat_view_o(stat_view)
  );
endmodule

// File: rtl/indirect_cmd_bridge_chk.sv
module indirect_cmd_bridge_chk #(
  parameter int HADDR_W   = 8,
  parameter int DADDR_W   = 32,
  parameter int MAX_BYTES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hreq_i,
  input logic               hwe_i,
  input logic [HADDR_W-1:0] haddr_i,
  input logic [3:0]         hsize_i,
  input logic [63:0]        hwdata_i,
  input logic               hack_o,
  input logic [63:0]        hrdata_o,
  input logic               dreq_o,
  input logic               dready_i,
  input logic [DADDR_W-1:0] daddr_o,
  input logic               busy_i
);
  logic full_wr, full_rd, ctl_wr, big;
  assign full_wr = hreq_i & hwe_i & (hsize_i == 4'd8);
  assign full_rd = hreq_i & ~hwe_i & (hsize_i == 4'd8);
  assign ctl_wr  = full_wr & (haddr_i[4:3] == 2'd0);
  assign big     = hwdata_i[59:56] > 4'(MAX_BYTES);

  p_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) hreq_i |=> hack_o);
  p_noack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) !hreq_i |=> !hack_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o && !dready_i |=> dreq_o && $stable(daddr_o));
  p_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && !big && !busy_i |=> dreq_o && daddr_o == $past(hwdata_i[DADDR_W-1:0]));
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && big && !busy_i |=> !dreq_o);
  p_busy_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && busy_i && !dreq_o |=> !dreq_o);
  p_busy_stat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rd && haddr_i[4:3] == 2'd2 && busy_i |=> hrdata_o == '0);
  p_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rd && !haddr_i[4] |=> hrdata_o == '0);
  p_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rd && haddr_i[4:3] == 2'd3 |=> hrdata_o[31:0] == '0);
  p_narrow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_i && hsize_i != 4'd8 |=> hrdata_o == '0);
endmodule

bind indirect_cmd_bridge indirect_cmd_bridge_chk #(
  .HADDR_W(HADDR_W), .DADDR_W(DADDR_W), .MAX_BYTES(MAX_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hreq_i(hreq_i), .hwe_i(hwe_i),
  .haddr_i(haddr_i), .hsize_i(hsize_i), .hwdata_i(hwdata_i),
  .hack_o(hack_o), .hrdata_o(hrdata_o), .dreq_o(dreq_o), .dready_i(dready_i),
  .daddr_o(daddr_o), .busy_i(busy)
);

// File: tb/indirect_cmd_bridge_tb.sv
module indirect_cmd_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq = 1'b0, hwe = 1'b0;
  logic [7:0]  haddr = '0;
  logic [3:0]  hsize = '0;
  logic [63:0] hwdata = '0;
  logic        hack;
  logic [63:0] hrdata;
  logic        dreq, dwe;
  logic        dready = 1'b0, drsp = 1'b0, derr = 1'b0;
  logic [31:0] daddr, dwdata;
  logic [31:0] drdata = '0;
  logic [3:0]  dsize;

  always #5 clk = ~clk;

  indirect_cmd_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hreq_i(hreq), .hwe_i(hwe), .haddr_i(haddr),
    .hsize_i(hsize), .hwdata_i(hwdata), .hack_o(hack), .hrdata_o(hrdata),
    .dreq_o(dreq), .dready_i(dready), .daddr_o(daddr), .dwe_o(dwe),
    .dsize_o(dsize), .dwdata_o(dwdata), .drsp_i(drsp), .drdata_i(drdata),
    .derr_i(derr)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_ack, m_busy, m_req, m_we;
  logic [63:0] m_rdata, m_stat;
  logic [31:0] m_data, m_addr, m_wdata;
  logic [3:0]  m_size;

  function automatic logic [31:0] swap4(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack <= 0; m_busy <= 0; m_req <= 0; m_we <= 0; m_rdata <= 0; m_stat <= 0;
      m_data <= 0; m_addr <= 0; m_wdata <= 0; m_size <= 0;
    end else begin
      automatic bit full = (hsize == 4'd8);
      automatic logic [1:0] s = haddr[4:3];
      m_ack   <= hreq;
      m_rdata <= 0;
      if (hreq && !hwe && full) begin
        if (s == 2) m_rdata <= m_busy ? 64'h0 : m_stat;
        if (s == 3) m_rdata <= {m_data, 32'h0};
        if (s == 2 && !m_busy) m_stat <= 0;
      end
      if (hreq && hwe && full && s == 3) m_data <= hwdata[63:32];
      if (hreq && hwe && full && s == 0 && !m_busy && hwdata[59:56] <= 4'd8) begin
        m_busy <= 1; m_req <= 1; m_addr <= hwdata[31:0]; m_we <= !hwdata[48];
        m_size <= hwdata[59:56]; m_wdata <= swap4(m_data); m_stat <= 0;
      end
      if (m_req && dready) m_req <= 0;
      else if (m_busy && !m_req && drsp) begin
        m_busy <= 0;
        m_stat <= m_we ? 64'h800 :
                  (64'h800 | ({32'h0, (derr ? 32'hFFFF_FFFF : swap4(drdata))} << 26));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(hack == m_ack, "R2 ack timing", {63'h0, hack}, {63'h0, m_ack});
      if (m_ack) chk(hrdata == m_rdata, "R1/R8/R9/R10/R11 read data", hrdata, m_rdata);
      chk(dreq == m_req, "R3/R4/R11 request valid", {63'h0, dreq}, {63'h0, m_req});
      if (m_req) begin
        chk({daddr, dwdata} == {m_addr, m_wdata}, "R3/R7 request addr+data",
            {daddr, dwdata}, {m_addr, m_wdata});
        chk({dwe, dsize} == {m_we, m_size}, "R3 request dir+size",
            {59'h0, dwe, dsize}, {59'h0, m_we, m_size});
      end
    end
  end

  // ---------------- downstream responder ----------------
  int          rdy_lat = 1, rsp_lat = 1, req_cnt = 0;
  logic [31:0] rsp_data = '0;
  bit          rsp_err = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_size;
  logic        cap_we;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dreq) begin
        repeat (rdy_lat) @(negedge clk);
        dready = 1; req_cnt++;
        cap_addr = daddr; cap_wdata = dwdata; cap_size = dsize; cap_we = dwe;
        @(negedge clk);
        dready = 0;
        repeat (rsp_lat) @(negedge clk);
        drsp = 1; drdata = rsp_data; derr = rsp_err;
        @(negedge clk);
        drsp = 0; drdata = '0; derr = 0;
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic host(input bit we, input logic [1:0] sel, input logic [3:0] sz,
                      input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    hreq = 1; hwe = we; haddr = {3'b0, sel, 3'b0}; hsize = sz; hwdata = wd;
    @(negedge clk);
    hreq = 0; hwe = 0; hwdata = '0; hsize = '0;
    rd = hrdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] wd);
    logic [63:0] dummy;
    host(1, sel, 4'd8, wd, dummy);
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] v);
    host(0, sel, 4'd8, 64'h0, v);
  endtask

  task automatic poll(output logic [63:0] v);
    v = 0;
    for (int i = 0; i < 100 && v == 0; i++) rd(2'd2, v);
  endtask

  function automatic logic [63:0] ctl(input bit is_rd, input logic [3:0] sz, input logic [31:0] a);
    return (64'(is_rd) << 48) | (64'(sz) << 56) | 64'(a);
  endfunction

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    logic [63:0] v;
    int n0;
    repeat (3) @(negedge clk);
    // reset state
    chk(hack == 0 && dreq == 0, "R2/R3 reset outputs", {62'h0, hack, dreq}, 64'h0);
    rst_n = 1;
    rd(2'd2, v); chk(v == 0, "R8 status after reset", v, 0);
    rd(2'd3, v); chk(v == 0, "R9 data after reset", v, 0);

    // R9 data register
    wr(2'd3, 64'hA1B2_C3D4_5555_6666);
    rd(2'd3, v); chk(v == 64'hA1B2_C3D4_0000_0000, "R9 data readback", v, 64'hA1B2_C3D4_0000_0000);

    // R10 control / reset read zero, reset write inert
    wr(2'd1, '1);
    rd(2'd1, v); chk(v == 0, "R10 reset reg reads zero", v, 0);
    rd(2'd0, v); chk(v == 0, "R10 control reg reads zero", v, 0);
    chk(dreq == 0, "R10 reset write launches nothing", {63'h0, dreq}, 0);
    rd(2'd3, v); chk(v == 64'hA1B2_C3D4_0000_0000, "R10 reset write keeps data", v, 64'hA1B2_C3D4_0000_0000);

    // R1 narrow accesses ignored
    host(1, 2'd3, 4'd4, 64'h1111_2222_0000_0000, v);
    host(0, 2'd3, 4'd4, 64'h0, v); chk(v == 0, "R1 narrow read zero", v, 0);
    rd(2'd3, v); chk(v == 64'hA1B2_C3D4_0000_0000, "R1 narrow write ignored", v, 64'hA1B2_C3D4_0000_0000);

    // R7 write op with downstream error, status write ignored (R8)
    rsp_err = 1; rdy_lat = 2; rsp_lat = 2; n0 = req_cnt;
    wr(2'd0, ctl(0, 4'd4, 32'h1234_5678));
    rd(2'd2, v); chk(v == 0, "R11 status zero in flight", v, 0);
    poll(v);
    chk(v == 64'h800, "R7 write done status", v, 64'h800);
    chk(cap_wdata == 32'hD4C3_B2A1, "R7 write byte order", 64'(cap_wdata), 64'hD4C3_B2A1);
    chk(cap_addr == 32'h1234_5678 && cap_we == 1 && cap_size == 4, "R3 write fields",
        {cap_addr, 27'h0, cap_we, cap_size}, {32'h1234_5678, 27'h0, 1'b1, 4'd4});
    chk(req_cnt == n0 + 1, "R3 one request per command", 64'(req_cnt), 64'(n0 + 1));
    rd(2'd2, v); chk(v == 0, "R8 status cleared by read", v, 0);

    // R5 successful read, byte order
    rsp_err = 0; rsp_data = 32'h4433_2211; rdy_lat = 0; rsp_lat = 0;
    wr(2'd0, ctl(1, 4'd4, 32'h0000_0040));
    poll(v);
    chk(v == (64'h800 | (64'h1122_3344 << 26)), "R5 read status", v, 64'h800 | (64'h1122_3344 << 26));

    // R8 status write ignored
    wr(2'd0, ctl(1, 4'd1, 32'h0000_0041));
    repeat (8) @(negedge clk);
    wr(2'd2, 64'h0);
    rd(2'd2, v); chk(v == (64'h800 | (64'h1122_3344 << 26)), "R8 status write ignored",
                     v, 64'h800 | (64'h1122_3344 << 26));

    // R6 failed read; leave unread, then R4 oversized command
    rsp_err = 1; rsp_lat = 1;
    wr(2'd0, ctl(1, 4'd4, 32'h0000_0080));
    repeat (10) @(negedge clk);
    n0 = req_cnt;
    wr(2'd0, ctl(1, 4'd9, 32'h0000_0090));
    repeat (6) @(negedge clk);
    chk(req_cnt == n0, "R4 oversize dropped", 64'(req_cnt), 64'(n0));
    rd(2'd2, v);
    chk(v == (64'h800 | (64'hFFFF_FFFF << 26)), "R6 error status kept by R4 drop",
        v, 64'h800 | (64'hFFFF_FFFF << 26));

    // R4 boundary: size 8 accepted
    rsp_err = 0; rsp_data = 32'h0;
    wr(2'd0, ctl(1, 4'd8, 32'h0000_00A0));
    poll(v);
    chk(cap_size == 4'd8, "R4 size 8 accepted", 64'(cap_size), 8);

    // R11 command while busy ignored
    rdy_lat = 12; n0 = req_cnt;
    wr(2'd0, ctl(0, 4'd2, 32'h0000_0B00));
    wr(2'd0, ctl(0, 4'd2, 32'h0000_0C00));
    rd(2'd2, v); chk(v == 0, "R11 status zero while busy", v, 0);
    poll(v);
    chk(cap_addr == 32'h0000_0B00, "R11 busy command ignored", 64'(cap_addr), 64'h0B00);
    repeat (5) @(negedge clk);
    chk(req_cnt == n0 + 1, "R11 single request", 64'(req_cnt), 64'(n0 + 1));

    finish_run();
  end
endmodule